// File: doc/BRIEF.md
# Two-Decade Fractional Pulse-Rate Generator

This block turns a stream of single-cycle input pulses into a thinner stream whose density is a two-digit decimal fraction of the input. It holds two decade stages. Each stage counts its own enabled steps from 0 to 9. Each stage also fires on a fixed subset of those ten positions, and a BCD digit selects that subset. The high stage always steps on every input pulse.

A mode bit decides how the low stage is fed and how the two outputs are combined. In sum mode the low stage steps only on the roll-over step of the high stage, so it weighs its digit by one hundredth. Its pulses are then merged with those of the high stage. In product mode the low stage steps on each pulse the high stage emits, and only the low stage drives the output. The two fractions therefore multiply.

A synchronous clear returns both stages to position 0. A strobe input blanks the output while counting goes on. The output is registered.

Top module: `frac_rate_gen`

## Requirements
- R1: After reset, and in the cycle after any clock edge that samples `clear` high, `pulse_o` is 0. `clear` returns both stage counters to position 0.
- R2: `pulse_o` is registered. With `mode_mul`=0 and `digit_hi`=9, the first enabled input pulse after clear makes `pulse_o` high one clock later. It is low in the following clock when `pulse_en` is low.
- R3: With `mode_mul`=0, 100 enabled input pulses starting from a cleared state give exactly 10·`digit_hi` + `digit_lo` output pulses, for every digit pair 0..9.
- R4: With `mode_mul`=0, the low stage steps only on the enabled pulse that rolls the high stage from 9 back to 0. The high stage never fires at position 9, so pulses from the two stages never coincide. With `digit_hi`=0, 100 pulses give exactly `digit_lo` pulses.
- R5: With `mode_mul`=1, the low stage steps once per output pulse of the high stage. 100 enabled pulses from a cleared state give exactly `digit_hi`·`digit_lo` output pulses.
- R6: While `strobe` is high, `pulse_o` stays 0 but both stages keep counting. After 100 strobed pulses, the next 100 unstrobed pulses give the full expected count.
- R7: A cycle with `pulse_en` low neither advances any stage nor produces an output pulse. Idle cycles between input pulses leave the counts of R3 and R5 unchanged.
- R8: Asserting `clear` part-way through a window restarts counting. The next 100 enabled pulses give the full expected count.
- R9: With both digits 0, `pulse_o` never rises, in either mode.
- R10: `mode_mul` changes only in a cycle where `clear` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous clear of both stages |
| mode_mul | input | 1 | 0 = sum of fractions, 1 = product of fractions |
| strobe | input | 1 | High blanks the output; counting continues |
| pulse_en | input | 1 | One input pulse per high cycle |
| digit_hi | input | 4 | BCD digit for the tenths stage (0..9) |
| digit_lo | input | 4 | BCD digit for the second stage (0..9) |
| pulse_o | output | 1 | Registered output pulse stream |

## Verification
The bench sweeps all hundred digit pairs in both modes. A wrong fire pattern, overlapping fire positions or a mis-wired carry would therefore show up as an off count for some pair; a high stage firing at position 9 would lose pulses in sum mode. Idle gaps between pulses expose a stage that advances without an enable. A full strobed window followed by an open one catches a strobe that freezes the counters instead of masking the output. A clear issued mid-window catches a low stage that keeps a stale position, which would shift the next product-mode count.

// File: rtl/frac_rate_pkg.sv
// Shared constants and the fire-position decode for the decade stages.
// Assumes BCD digits 0..9; larger codes give overlapping, undefined densities.
package frac_rate_pkg;
    localparam int DIGIT_W = 4;
    localparam int RADIX   = 10;
    localparam int CNT_W   = $clog2(RADIX);

    typedef logic [CNT_W-1:0]   pos_t;
    typedef logic [DIGIT_W-1:0] digit_t;

    // Weight-8 bit fires on positions 0..7, weight-4 bit on 0,2,4,6,
    // weight-2 bit on 1,5, weight-1 bit on 8. Position 9 never fires.
    function automatic logic lane_hit(input digit_t d, input pos_t p);
        logic w8, w4, w2, w1;
        w8 = d[3] && (p <= pos_t'(7));
        w4 = d[2] && (p[0] == 1'b0) && (p <= pos_t'(6));
        w2 = d[1] && ((p == pos_t'(1)) || (p == pos_t'(5)));
        w1 = d[0] && (p == pos_t'(8));
        return w8 || w4 || w2 || w1;
    endfunction
endpackage

// File: rtl/decade_stage.sv
// One decade stage: a 0..RADIX-1 position counter that advances on each
// step, plus a combinational fire and roll-over carry for that step.
// Assumes step is a single-cycle qualifier in the clk domain.
module decade_stage
    import frac_rate_pkg::*;
#(
    parameter int LAST = RADIX - 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   step,
    input  digit_t digit,
    output logic   fire,
    output logic   carry
);
    pos_t pos_q;
    logic at_last;

    assign at_last = (pos_q == pos_t'(LAST));

    // Advance position on each step, wrapping at LAST; clear forces 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            pos_q <= '0;
        else if (step)
            pos_q <= at_last ? '0 : pos_q + pos_t'(1);
    end

    // Fire when the current step lands on a selected position.
    always_comb fire = step && lane_hit(digit, pos_q);

    // Carry on the step that wraps the counter.
    always_comb carry = step && at_last;
endmodule

// File: rtl/rate_link.sv
// Routing between the two stages: picks what steps the low stage and
// what feeds the output. Assumes mode is static outside of clear.
module rate_link (
    input  logic mode_mul,
    input  logic hi_fire,
    input  logic hi_carry,
    input  logic lo_fire,
    output logic lo_step,
    output logic merged
);
    // Product mode chains on high-stage pulses; sum mode on its roll-over.
    always_comb lo_step = mode_mul ? hi_fire : hi_carry;

    // Product mode passes only the low stage; sum mode merges both.
    always_comb merged = mode_mul ? lo_fire : (hi_fire || lo_fire);
endmodule

// File: rtl/frac_rate_gen.sv
// Two-decade fractional pulse-rate generator. The high stage steps on every
// input pulse; the mode bit picks sum or product chaining of the low stage.
// The merged pulse is registered, blanked by strobe and clear.
// Assumes mode_mul changes only while clear is high.
module frac_rate_gen
    import frac_rate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               mode_mul,
    input  logic               strobe,
    input  logic               pulse_en,
    input  logic [DIGIT_W-1:0] digit_hi,
    input  logic [DIGIT_W-1:0] digit_lo,
    output logic               pulse_o
);
    logic hi_fire, hi_carry, lo_fire, lo_carry, lo_step, merged;

    decade_stage u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (pulse_en),
        .digit (digit_hi),
        .fire  (hi_fire),
        .carry (hi_carry)
    );

    decade_stage u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (lo_step),
        .digit (digit_lo),
        .fire  (lo_fire),
        .carry (lo_carry)
    );

    rate_link u_link (
        .mode_mul (mode_mul),
        .hi_fire  (hi_fire),
        .hi_carry (hi_carry),
        .lo_fire  (lo_fire),
        .lo_step  (lo_step),
        .merged   (merged)
    );

    // Register the output pulse, masked by strobe and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_o <= 1'b0;
        else
            pulse_o <= merged && !strobe && !clear;
    end

    logic unused_lo_carry;
    assign unused_lo_carry = lo_carry;
endmodule

// File: rtl/frac_rate_gen_chk.sv
// Port-level properties of frac_rate_gen, bound to every instance.
// Assumes the synchronous active-low reset of the block.
module frac_rate_gen_chk
    import frac_rate_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               clear,
    input logic               mode_mul,
    input logic               strobe,
    input logic               pulse_en,
    input logic [DIGIT_W-1:0] digit_hi,
    input logic [DIGIT_W-1:0] digit_lo,
    input logic               pulse_o
);
    p_clear_silences_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pulse_o);

    p_strobe_blanks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !pulse_o);

    p_idle_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_en |=> !pulse_o);

    p_zero_digits_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_hi == '0 && digit_lo == '0) |=> !pulse_o);

    p_mode_under_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_mul) |-> clear);
endmodule

bind frac_rate_gen frac_rate_gen_chk i_chk (.*);

// File: tb/test_frac_rate_gen.sv
module test_frac_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       mode_mul = 1'b0;
    logic       strobe = 1'b0;
    logic       pulse_en = 1'b0;
    logic [3:0] digit_hi = '0;
    logic [3:0] digit_lo = '0;
    logic       pulse_o;

    int checks = 0;
    int fails  = 0;
    int cnt;

    always #2 clk = ~clk;

    frac_rate_gen i_frac_rate_gen (.*);

    // {mode, hi, lo, gap cycles, expected per 100 pulses}
    localparam int NVEC = 8;
    localparam int VEC [NVEC][5] = '{
        '{0, 9, 4, 0, 94}, '{1, 9, 4, 0, 36}, '{0, 0, 4, 0, 4},
        '{0, 9, 0, 2, 90}, '{1, 9, 9, 1, 81}, '{1, 1, 1, 3, 1},
        '{0, 9, 9, 1, 99}, '{1, 5, 0, 0, 0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_clear(input logic new_mode);
        @(negedge clk) clear = 1'b1;
        @(negedge clk) mode_mul = new_mode;
        @(negedge clk) clear = 1'b0;
    endtask

    // Give n enabled pulses with gap idle cycles after each; count outputs.
    task automatic run(input int n, input int gap);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt += int'(pulse_o);
            pulse_en = 1'b1;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                cnt += int'(pulse_o);
                pulse_en = 1'b0;
            end
        end
        @(negedge clk);
        cnt += int'(pulse_o);
        pulse_en = 1'b0;
        @(negedge clk);
        cnt += int'(pulse_o);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pulse_o == 1'b0, "R1 reset output", int'(pulse_o), 0);
        rst_n = 1'b1;

        // Vector table (R3 R5 R7)
        for (int v = 0; v < NVEC; v++) begin
            digit_hi = 4'(VEC[v][1]);
            digit_lo = 4'(VEC[v][2]);
            do_clear(1'(VEC[v][0]));
            run(100, VEC[v][3]);
            check(cnt == VEC[v][4], VEC[v][3] != 0 ? "R7 gapped window" : "R3/R5 table window",
                  cnt, VEC[v][4]);
        end

        // Full sweep: R3 R4 sum mode, R5 product mode, R9 zero digits
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 10; a++) begin
                for (int b = 0; b < 10; b++) begin
                    int exp;
                    exp = (m == 0) ? 10 * a + b : a * b;
                    digit_hi = 4'(a);
                    digit_lo = 4'(b);
                    do_clear(1'(m));
                    run(100, 0);
                    if (a == 0 && b == 0)
                        check(cnt == 0, "R9 zero digits", cnt, 0);
                    else if (m == 0 && a == 0)
                        check(cnt == exp, "R4 low stage only", cnt, exp);
                    else if (m == 0)
                        check(cnt == exp, "R3 sum sweep", cnt, exp);
                    else
                        check(cnt == exp, "R5 product sweep", cnt, exp);
                end
            end
        end

        // R2 latency: first pulse after clear with high digit 9
        digit_hi = 4'd9;
        digit_lo = 4'd0;
        do_clear(1'b0);
        @(negedge clk) pulse_en = 1'b1;
        @(negedge clk);
        check(pulse_o == 1'b1, "R2 one-cycle latency", int'(pulse_o), 1);
        pulse_en = 1'b0;
        @(negedge clk);
        check(pulse_o == 1'b0, "R2 drops after idle", int'(pulse_o), 0);

        // R1 clear blanks output in the following cycle
        @(negedge clk) begin
            pulse_en = 1'b1;
            clear = 1'b1;
        end
        @(negedge clk);
        check(pulse_o == 1'b0, "R1 clear blanks", int'(pulse_o), 0);
        pulse_en = 1'b0;
        clear = 1'b0;

        // R6 strobe: count continues while blanked, both modes
        for (int m = 0; m < 2; m++) begin
            digit_hi = 4'd9;
            digit_lo = 4'd4;
            do_clear(1'(m));
            strobe = 1'b1;
            run(100, 0);
            check(cnt == 0, "R6 strobed window", cnt, 0);
            strobe = 1'b0;
            run(100, 0);
            check(cnt == (m == 0 ? 94 : 36), "R6 after strobe", cnt, m == 0 ? 94 : 36);
        end

        // R8 clear part-way through a window, both modes
        for (int m = 0; m < 2; m++) begin
            digit_hi = 4'd7;
            digit_lo = 4'd3;
            do_clear(1'(m));
            run(37, 0);
            do_clear(1'(m));
            run(100, 0);
            check(cnt == (m == 0 ? 73 : 21), "R8 restart after clear", cnt, m == 0 ? 73 : 21);
        end

        finish_run();
    end
endmodule